// File: doc/BRIEF.md
# In-Order Multi-Issue Hazard Checker

This block sits at the issue point of a statically scheduled superscalar core. Each cycle the upstream stage presents a packet of up to three decoded instructions in program order. Each slot carries a valid bit, two source register indices, a destination register index and a flag that says whether the destination is written. The checker compares every candidate slot with a scoreboard of destination registers that instructions already in the execution pipeline have not yet written back. It also compares each slot with the older, still unissued slots of the same packet. It then issues the longest run of candidates, starting from the oldest, that is free of hazards.

A slot that stalls blocks every younger slot, so instructions never overtake one another. The slots that were not issued stay in place. The block records which slots of the held packet have already gone, so they are not issued a second time. It raises `pkt_ready` only in the cycle in which the last remaining valid slot issues. Writeback ports clear scoreboard bits, and register 0 is never tracked.

Top module: `iss_issue_ctl`

## Requirements
- R1: After reset every pending bit is 0, no slot fires, `iss_count` is 0 and `pkt_ready` is 1 while `pkt_valid` is low.
- R2: A candidate slot does not fire while either of its nonzero source registers is pending in the scoreboard (read-after-write against in-flight work).
- R3: A candidate slot with the write flag set does not fire while its nonzero destination is pending (write-after-write against in-flight work).
- R4: A slot does not fire in a cycle when an older candidate slot of the same packet writes a nonzero register that the slot reads.
- R5: A writing slot does not fire in a cycle when an older candidate slot of the same packet writes the same nonzero destination.
- R6: Issue is a prefix. Once a candidate slot stalls, no younger slot fires in that cycle. Slots with the valid bit at 0 are skipped and block nothing. Bit i of `iss_fire` corresponds to slot i, and slot 0 is the oldest.
- R7: Register index 0 never causes a hazard and is never marked pending.
- R8: An issued slot that writes register r sets pending bit r from the next cycle on. A writeback of r clears the bit from the next cycle on, and the clear is not visible to the hazard check in its own cycle. When a set and a clear of the same register fall in the same cycle, the bit ends up set.
- R9: A packet is held while any of its valid slots has not issued. `pkt_ready` stays 0 until the cycle in which the last remaining slot fires. Slots that have already issued do not fire again.
- R10: `iss_count` equals the number of bits set in `iss_fire`.
- R11: A synchronous reset clears all pending bits and discards the issue progress of a partly issued packet, so the packet issues again from slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_valid | input | 1 | Upstream presents a packet |
| pkt_ready | output | 1 | Packet fully issued this cycle; upstream may advance |
| in_vld | input | 3 | Per-slot valid bits |
| in_rs1 | input | 3x5 | First source register per slot |
| in_rs2 | input | 3x5 | Second source register per slot |
| in_rd | input | 3x5 | Destination register per slot |
| in_wr | input | 3 | Per-slot destination-write flag |
| wb_vld | input | 2 | Writeback port valid bits |
| wb_reg | input | 2x5 | Register written back per port |
| iss_fire | output | 3 | Slots issued this cycle |
| iss_count | output | 2 | Number of slots issued this cycle |
| pend_mask | output | 32 | Scoreboard of pending destination registers |

## Verification
The directed cases go after the blocking rules, one at a time. A reader of a register written by an older slot in the same packet must wait; a design that compared only against the scoreboard would issue it a cycle early. A second writer to the same register must wait as well, or the final value would be lost. A stalled slot must hold back independent younger slots, which an out-of-order picker would let through. The remaining cases cover a writeback arriving in the same cycle as a stalled reader, which a design with a bypass would let fire early, and a set and a clear of one register in the same cycle, where giving the clear priority loses the new writer. Register 0 must never be tracked, and a mid-packet reset must drop the issue progress so that no slot is skipped. A long pseudo-random sweep over four registers then checks the issue mask, the count, the ready flag and the scoreboard against an arithmetic model computed in the bench.

// File: rtl/iss_pkg.sv
package iss_pkg;
    parameter int unsigned SLOTS    = 3;
    parameter int unsigned NREGS    = 32;
    parameter int unsigned WB_PORTS = 2;

    localparam int unsigned RIDX_W = $clog2(NREGS);
    localparam int unsigned CNT_W  = $clog2(SLOTS + 1);

    typedef logic [RIDX_W-1:0] ridx_t;

    typedef struct packed {
        logic  vld;
        ridx_t rs1;
        ridx_t rs2;
        ridx_t rd;
        logic  wr;
    } slot_t;

    // True when the slot reads register r; register 0 is never a real source
    function automatic logic slot_reads(slot_t s, ridx_t r);
        return (r != '0) && ((s.rs1 == r) || (s.rs2 == r));
    endfunction

    // Destination actually written (nonzero index with write flag)
    function automatic logic slot_writes(slot_t s);
        return s.wr && (s.rd != '0);
    endfunction
endpackage

// File: rtl/iss_scoreboard.sv
module iss_scoreboard
    import iss_pkg::*;
#(
    parameter int unsigned N_SET = SLOTS,
    parameter int unsigned N_CLR = WB_PORTS
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [N_SET-1:0]            set_vld,
    input  logic [N_SET-1:0][RIDX_W-1:0] set_reg,
    input  logic [N_CLR-1:0]            clr_vld,
    input  logic [N_CLR-1:0][RIDX_W-1:0] clr_reg,
    output logic [NREGS-1:0]            pend
);
    logic [NREGS-1:0] set_vec;
    logic [NREGS-1:0] clr_vec;

    always_comb begin
        set_vec = '0;
        clr_vec = '0;
        for (int s = 0; s < int'(N_SET); s++) begin
            if (set_vld[s]) set_vec[set_reg[s]] = 1'b1;
        end
        for (int c = 0; c < int'(N_CLR); c++) begin
            if (clr_vld[c]) clr_vec[clr_reg[c]] = 1'b1;
        end
        set_vec[0] = 1'b0;
    end

    // Set wins over a clear of the same register in the same cycle
    always_ff @(posedge clk) begin
        if (rst) pend <= '0;
        else     pend <= (pend & ~clr_vec) | set_vec;
    end
endmodule

// File: rtl/iss_hazard.sv
module iss_hazard
    import iss_pkg::*;
#(
    parameter int unsigned N = SLOTS
) (
    input  slot_t [N-1:0]     slots,
    input  logic  [N-1:0]     cand,
    input  logic  [NREGS-1:0] pend,
    output logic  [N-1:0]     haz
);
    for (genvar i = 0; i < int'(N); i++) begin : g_slot
        logic infl;
        logic intra;

        always_comb begin
            infl = ((slots[i].rs1 != '0) && pend[slots[i].rs1])
                || ((slots[i].rs2 != '0) && pend[slots[i].rs2])
                || (slot_writes(slots[i]) && pend[slots[i].rd]);
            intra = 1'b0;
            for (int j = 0; j < i; j++) begin
                if (cand[j] && slot_writes(slots[j])) begin
                    if (slot_reads(slots[i], slots[j].rd)) intra = 1'b1;
                    if (slot_writes(slots[i]) && (slots[i].rd == slots[j].rd)) intra = 1'b1;
                end
            end
        end

        assign haz[i] = infl | intra;
    end
endmodule

// File: rtl/iss_select.sv
module iss_select
    import iss_pkg::*;
#(
    parameter int unsigned N = SLOTS
) (
    input  logic [N-1:0]     cand,
    input  logic [N-1:0]     haz,
    output logic [N-1:0]     fire,
    output logic [CNT_W-1:0] count
);
    logic blocked;

    always_comb begin
        blocked = 1'b0;
        fire    = '0;
        count   = '0;
        for (int i = 0; i < int'(N); i++) begin
            if (cand[i]) begin
                if (blocked || haz[i]) blocked = 1'b1;
                else                   fire[i] = 1'b1;
            end
        end
        for (int i = 0; i < int'(N); i++) begin
            count = count + CNT_W'(fire[i]);
        end
    end
endmodule

// File: rtl/iss_issue_ctl.sv
module iss_issue_ctl
    import iss_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          pkt_valid,
    output logic                          pkt_ready,
    input  logic [SLOTS-1:0]              in_vld,
    input  logic [SLOTS-1:0][RIDX_W-1:0]  in_rs1,
    input  logic [SLOTS-1:0][RIDX_W-1:0]  in_rs2,
    input  logic [SLOTS-1:0][RIDX_W-1:0]  in_rd,
    input  logic [SLOTS-1:0]              in_wr,
    input  logic [WB_PORTS-1:0]           wb_vld,
    input  logic [WB_PORTS-1:0][RIDX_W-1:0] wb_reg,
    output logic [SLOTS-1:0]              iss_fire,
    output logic [CNT_W-1:0]              iss_count,
    output logic [NREGS-1:0]              pend_mask
);
    slot_t [SLOTS-1:0] slots;
    logic  [SLOTS-1:0] done_q;
    logic  [SLOTS-1:0] cand;
    logic  [SLOTS-1:0] haz;
    logic  [SLOTS-1:0] set_vld;

    for (genvar i = 0; i < int'(SLOTS); i++) begin : g_pack
        assign slots[i] = '{vld: in_vld[i], rs1: in_rs1[i], rs2: in_rs2[i],
                            rd: in_rd[i], wr: in_wr[i]};
    end

    assign cand      = pkt_valid ? (in_vld & ~done_q) : '0;
    assign pkt_ready = (iss_fire == cand);
    assign set_vld   = iss_fire & in_wr;

    iss_scoreboard #(.N_SET(SLOTS), .N_CLR(WB_PORTS)) u_sb (
        .clk     (clk),
        .rst     (rst),
        .set_vld (set_vld),
        .set_reg (in_rd),
        .clr_vld (wb_vld),
        .clr_reg (wb_reg),
        .pend    (pend_mask)
    );

    iss_hazard #(.N(SLOTS)) u_haz (
        .slots (slots),
        .cand  (cand),
        .pend  (pend_mask),
        .haz   (haz)
    );

    iss_select #(.N(SLOTS)) u_sel (
        .cand  (cand),
        .haz   (haz),
        .fire  (iss_fire),
        .count (iss_count)
    );

    // Progress through the held packet
    always_ff @(posedge clk) begin
        if (rst)                          done_q <= '0;
        else if (pkt_valid && pkt_ready)  done_q <= '0;
        else if (pkt_valid)               done_q <= done_q | iss_fire;
    end
endmodule

// File: rtl/iss_checker.sv
module iss_checker
    import iss_pkg::*;
(
    input logic                         clk,
    input logic                         rst,
    input logic                         pkt_valid,
    input logic                         pkt_ready,
    input logic [SLOTS-1:0]             in_vld,
    input logic [SLOTS-1:0][RIDX_W-1:0] in_rs1,
    input logic [SLOTS-1:0][RIDX_W-1:0] in_rs2,
    input logic [SLOTS-1:0][RIDX_W-1:0] in_rd,
    input logic [SLOTS-1:0]             in_wr,
    input logic [SLOTS-1:0]             iss_fire,
    input logic [NREGS-1:0]             pend_mask,
    input logic [SLOTS-1:0]             done_q
);
    logic [SLOTS-1:0] left_behind;
    assign left_behind = pkt_valid ? (in_vld & ~done_q & ~iss_fire) : '0;

    p_reg0_clear_r7: assert property (@(posedge clk) disable iff (rst)
        !pend_mask[0]);

    p_idle_no_fire_r6: assert property (@(posedge clk) disable iff (rst)
        !pkt_valid |-> (iss_fire == '0));

    p_fire_valid_r6: assert property (@(posedge clk) disable iff (rst)
        (iss_fire & ~in_vld) == '0);

    p_no_reissue_r9: assert property (@(posedge clk) disable iff (rst)
        (iss_fire & done_q) == '0);

    p_accept_clears_r9: assert property (@(posedge clk) disable iff (rst)
        (pkt_valid && pkt_ready) |=> (done_q == '0));

    for (genvar i = 0; i < int'(SLOTS); i++) begin : g_chk
        p_prefix_r6: assert property (@(posedge clk) disable iff (rst)
            left_behind[i] |-> ((iss_fire >> i) == '0));

        p_src1_free_r2: assert property (@(posedge clk) disable iff (rst)
            (iss_fire[i] && in_rs1[i] != '0) |-> !pend_mask[in_rs1[i]]);

        p_src2_free_r2: assert property (@(posedge clk) disable iff (rst)
            (iss_fire[i] && in_rs2[i] != '0) |-> !pend_mask[in_rs2[i]]);

        p_dst_free_r3: assert property (@(posedge clk) disable iff (rst)
            (iss_fire[i] && in_wr[i] && in_rd[i] != '0) |-> !pend_mask[in_rd[i]]);

        p_set_next_r8: assert property (@(posedge clk) disable iff (rst)
            (iss_fire[i] && in_wr[i] && in_rd[i] != '0) |=> pend_mask[$past(in_rd[i])]);
    end
endmodule

bind iss_issue_ctl iss_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .pkt_valid (pkt_valid),
    .pkt_ready (pkt_ready),
    .in_vld    (in_vld),
    .in_rs1    (in_rs1),
    .in_rs2    (in_rs2),
    .in_rd     (in_rd),
    .in_wr     (in_wr),
    .iss_fire  (iss_fire),
    .pend_mask (pend_mask),
    .done_q    (done_q)
);

// File: tb/iss_issue_ctl_tb.sv
`timescale 1ns/1ps
module iss_issue_ctl_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic            pv;
    logic            rdy;
    logic [2:0]      vld, we;
    logic [2:0][4:0] rs1, rs2, rd;
    logic [1:0]      wbv;
    logic [1:0][4:0] wbr;
    logic [2:0]      fire;
    logic [1:0]      cnt;
    logic [31:0]     pend;

    iss_issue_ctl u_dut (
        .clk(clk), .rst(rst), .pkt_valid(pv), .pkt_ready(rdy),
        .in_vld(vld), .in_rs1(rs1), .in_rs2(rs2), .in_rd(rd), .in_wr(we),
        .wb_vld(wbv), .wb_reg(wbr), .iss_fire(fire), .iss_count(cnt),
        .pend_mask(pend)
    );

    int nchk = 0;
    int nerr = 0;
    logic [31:0] mpend;
    logic [2:0]  mdone;
    logic        last_acc;

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    task automatic clr_pkt();
        pv = 0; vld = '0; we = '0; rs1 = '0; rs2 = '0; rd = '0;
        wbv = '0; wbr = '0;
    endtask

    task automatic slot(input int i, input logic v, input int a, input int b,
                        input int d, input logic w);
        vld[i] = v; rs1[i] = 5'(a); rs2[i] = 5'(b); rd[i] = 5'(d); we[i] = w;
    endtask

    function automatic logic rdz(input logic [31:0] p, input logic [4:0] r);
        return (r != 0) && p[r];
    endfunction

    // One cycle: compare outputs with the model, then advance the model
    task automatic step(input string tag);
        logic [2:0] cand, efire;
        logic blk, hz;
        int ecnt;
        #1;
        cand = pv ? (vld & ~mdone) : 3'b000;
        efire = 0; blk = 0; ecnt = 0;
        for (int i = 0; i < 3; i++) begin
            if (cand[i]) begin
                hz = rdz(mpend, rs1[i]) || rdz(mpend, rs2[i]) || (we[i] && rdz(mpend, rd[i]));
                for (int j = 0; j < i; j++) begin
                    if (cand[j] && we[j] && rd[j] != 0) begin
                        if (rs1[i] == rd[j] || rs2[i] == rd[j]) hz = 1;
                        if (we[i] && rd[i] == rd[j]) hz = 1;
                    end
                end
                if (blk || hz) blk = 1;
                else begin efire[i] = 1; ecnt++; end
            end
        end
        chk(tag, "fire", 32'(fire), 32'(efire));
        chk(tag, "count", 32'(cnt), 32'(ecnt));
        chk(tag, "ready", 32'(rdy), 32'(efire == cand));
        chk(tag, "pend", pend, mpend);
        last_acc = pv && (efire == cand);
        @(posedge clk);
        for (int k = 0; k < 2; k++) if (wbv[k]) mpend[wbr[k]] = 1'b0;
        for (int i = 0; i < 3; i++) if (efire[i] && we[i] && rd[i] != 0) mpend[rd[i]] = 1'b1;
        if (pv) mdone = last_acc ? 3'b000 : (mdone | efire);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1; clr_pkt();
        @(posedge clk); @(posedge clk);
        mpend = '0; mdone = '0;
        @(negedge clk);
        rst = 0;
    endtask

    initial begin
        #(4 * 200000);
        nerr++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        clr_pkt();
        mpend = '0; mdone = '0; last_acc = 0;
        @(negedge clk);
        do_reset();
        step("R1");

        // R2: reader of an in-flight destination waits; R8 no same-cycle bypass
        pv = 1; slot(0, 1, 0, 0, 5, 1); step("R2");
        clr_pkt(); pv = 1; slot(0, 1, 5, 0, 6, 1); step("R2");
        wbv[0] = 1; wbr[0] = 5; step("R8");
        wbv = '0; step("R2");
        clr_pkt(); step("R2");

        // R3: writer to a pending destination waits
        pv = 1; slot(0, 1, 0, 0, 6, 1); step("R3");
        wbv[1] = 1; wbr[1] = 6; step("R3");
        wbv = '0; step("R3");
        clr_pkt(); wbv[0] = 1; wbr[0] = 6; step("R3");
        clr_pkt(); step("R3");

        // R4: in-packet read-after-write; R9 partial issue holds the packet
        pv = 1; slot(0, 1, 0, 0, 7, 1); slot(1, 1, 3, 7, 0, 0); slot(2, 1, 0, 0, 8, 1);
        step("R4"); step("R9");
        wbv[0] = 1; wbr[0] = 7; step("R9");
        wbv = '0; step("R10");
        clr_pkt(); wbv[0] = 1; wbr[0] = 8; step("R4");
        clr_pkt(); step("R4");

        // R5: in-packet write-after-write
        pv = 1; slot(0, 1, 0, 0, 9, 1); slot(1, 1, 0, 0, 9, 1); step("R5");
        wbv[1] = 1; wbr[1] = 9; step("R5");
        wbv = '0; step("R5");
        clr_pkt(); wbv[0] = 1; wbr[0] = 9; step("R5");

        // R6: invalid slot skipped; stalled slot blocks younger ones
        clr_pkt(); pv = 1; slot(0, 0, 0, 0, 0, 0); slot(1, 1, 0, 0, 11, 1); slot(2, 1, 0, 0, 12, 1);
        step("R6");
        clr_pkt(); pv = 1; slot(0, 1, 11, 0, 0, 0); slot(1, 1, 0, 0, 13, 1); slot(2, 1, 4, 4, 0, 0);
        step("R6");
        wbv[0] = 1; wbr[0] = 11; wbv[1] = 1; wbr[1] = 12; step("R6");
        wbv = '0; step("R6");
        clr_pkt(); wbv[0] = 1; wbr[0] = 13; step("R6");

        // R7: register 0 never a hazard nor pending
        clr_pkt(); pv = 1; slot(0, 1, 0, 0, 0, 1); slot(1, 1, 0, 0, 0, 1); slot(2, 1, 0, 0, 0, 1);
        step("R7");
        clr_pkt(); step("R7");

        // R8: set and clear of the same register in one cycle leaves it set
        pv = 1; slot(0, 1, 0, 0, 16, 1); wbv[0] = 1; wbr[0] = 16; step("R8");
        clr_pkt(); step("R8");
        wbv[1] = 1; wbr[1] = 16; step("R8");
        clr_pkt(); step("R8");

        // R11: reset drops partial progress and the scoreboard
        pv = 1; slot(0, 1, 0, 0, 17, 1); slot(1, 1, 17, 0, 0, 0); step("R11");
        do_reset(); step("R11");
        pv = 1; slot(0, 1, 0, 0, 17, 1); slot(1, 1, 17, 0, 0, 0); step("R11");
        wbv[0] = 1; wbr[0] = 17; step("R11");
        wbv = '0; step("R11");
        clr_pkt(); step("R11");

        // Pseudo-random sweep over registers 0..3
        last_acc = 1;
        for (int c = 0; c < 4000; c++) begin
            if (!pv || last_acc) begin
                pv = ($urandom_range(0, 7) != 0);
                for (int i = 0; i < 3; i++)
                    slot(i, 1'($urandom_range(0, 3) != 0), $urandom_range(0, 3),
                         $urandom_range(0, 3), $urandom_range(0, 3), 1'($urandom_range(0, 1)));
            end
            for (int k = 0; k < 2; k++) begin
                wbv[k] = 1'($urandom_range(0, 2) == 0);
                wbr[k] = 5'($urandom_range(0, 3));
            end
            step("R10");
        end

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule